// File: doc/BRIEF.md
# Prioritized Event Vector Controller

This block gathers the one-cycle event pulses that a serial bus controller's engine produces and holds each one as a sticky flag in a 16-bit status register. A 16-bit enable register gates the flags. Of the flags that are both set and enabled, the one with the lowest code is offered as a small number in a read-only vector register. A single interrupt request line stays high while any enabled flag is pending.

A handler clears flags in one of two ways. It can read the vector register, which clears the flag being reported. It can also write ones to the status register. A handler can therefore read the vector, service that event and read again, and stop when the vector reads zero. Two level inputs, bus busy and receive shift register full, are shown in the status register. They never raise a vector or an interrupt.

Register reads are combinational from the current state, at the address presented. The read strobe has only one effect: it allows the clearing side effect of a vector read. Writes take effect at the clock edge.

Top module: `evt_vector_ctrl`

## Requirements
- R1: The enable register sits at offset 0x04. Bits 0..6 can be written and read back. Bits 7..15 always read 0.
- R2: Each event pulse sets its status flag at the next clock edge. The flag positions are: arbitration lost bit 0, no-acknowledge bit 1, access ready bit 2, receive ready bit 3, transmit ready bit 4, stop detected bit 5, addressed-as-slave bit 6. Status is read at offset 0x08.
- R3: Writing a 1 to a status bit 0..6 clears that flag. Writing 0 leaves the flag unchanged.
- R4: The vector register at offset 0x28 reports these codes: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed-as-slave 7. It reads 0 when no enabled flag is pending.
- R5: When several enabled flags are pending, the vector reports the lowest code among them.
- R6: A strobed read of the vector clears the flag it reports. The next read then shows the next pending code.
- R7: The interrupt output is high exactly when some status flag and its enable bit are both set.
- R8: An event pulse that arrives in the same cycle as a clear of that flag leaves the flag set. This holds for a status write and for a vector read alike.
- R9: Status bit 11 follows the receive-shift-full input and bit 12 follows the bus-busy input. Neither bit produces a vector or an interrupt, and writing ones to them does not clear them.
- R10: A flag whose enable bit is 0 is still visible in status, but it does not affect the vector or the interrupt output.
- R11: After reset the enable register, all flags, the vector and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; enables the vector-read clear |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| evt_nack | input | 1 | No-acknowledge pulse |
| evt_acc_rdy | input | 1 | Access ready pulse |
| evt_rx_rdy | input | 1 | Receive ready pulse |
| evt_tx_rdy | input | 1 | Transmit ready pulse |
| evt_stop | input | 1 | Stop detected pulse |
| evt_slave_addr | input | 1 | Addressed-as-slave pulse |
| lvl_shift_full | input | 1 | Receive shift register full level |
| lvl_bus_busy | input | 1 | Bus busy level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a race: an event pulse landing in exactly the same clock cycle as the clear of its own flag. That clear can come from a status write or from a strobed vector read. The bench drives the event pulse and the clearing strobe in the same half-cycle window, so that both are sampled by a single edge. It then inspects status and the vector to confirm that the flag survived. A second hard case is draining several pending codes in priority order through repeated strobed reads, with each read taking effect before the next one.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int EVC_DATA_W = 16;
  localparam int EVC_ADDR_W = 6;
  localparam int EVC_NUM_EVT = 7;
  localparam int EVC_CODE_W = $clog2(EVC_NUM_EVT + 1);

  localparam logic [EVC_ADDR_W-1:0] OFF_ENABLE = 6'h04;
  localparam logic [EVC_ADDR_W-1:0] OFF_STATUS = 6'h08;
  localparam logic [EVC_ADDR_W-1:0] OFF_VECTOR = 6'h28;

  localparam int BIT_SHIFT_FULL = 11;
  localparam int BIT_BUS_BUSY   = 12;

  // Turns a one-hot grant into its code (bit index + 1); returns 0 for none.
  function automatic logic [EVC_CODE_W-1:0] grant_to_code(
      input logic [EVC_NUM_EVT-1:0] grant);
    logic [EVC_CODE_W-1:0] c;
    c = '0;
    for (int i = 0; i < EVC_NUM_EVT; i++) begin
      if (grant[i]) c = c | EVC_CODE_W'(i + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/evc_flag_bank.sv
module evc_flag_bank #(
  parameter int N = evc_pkg::EVC_NUM_EVT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  // Each flag is a sticky bit: a set in the same cycle as a clear keeps it set.
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evc_prio_enc.sv
module evc_prio_enc #(
  parameter int N  = evc_pkg::EVC_NUM_EVT,
  parameter int CW = evc_pkg::EVC_CODE_W
) (
  input  logic [N-1:0]  pending,
  output logic [N-1:0]  grant,
  output logic [CW-1:0] code,
  output logic          any
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;
  // Ripple chain: bit i is granted only if no lower bit is pending.
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = pending[i] & ~seen[i];
    assign seen[i+1] = seen[i] | pending[i];
  end

  assign any  = seen[N];
  assign code = CW'(evc_pkg::grant_to_code(evc_pkg::EVC_NUM_EVT'(grant)));
endmodule

// File: rtl/evc_reg_if.sv
module evc_reg_if #(
  parameter int DW = evc_pkg::EVC_DATA_W,
  parameter int AW = evc_pkg::EVC_ADDR_W,
  parameter int N  = evc_pkg::EVC_NUM_EVT,
  parameter int CW = evc_pkg::EVC_CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  flags,
  input  logic          shift_full,
  input  logic          bus_busy,
  input  logic [N-1:0]  grant,
  input  logic [CW-1:0] code,
  output logic [DW-1:0] rdata,
  output logic [N-1:0]  enable,
  output logic [N-1:0]  w1c_vec,
  output logic [N-1:0]  vec_clr
);
  import evc_pkg::*;

  logic hit_enable, hit_status, hit_vector;
  logic unused_wdata;

  assign hit_enable   = (addr == OFF_ENABLE);
  assign hit_status   = (addr == OFF_STATUS);
  assign hit_vector   = (addr == OFF_VECTOR);
  assign unused_wdata = ^wdata[DW-1:N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                enable <= '0;
    else if (wr && hit_enable) enable <= wdata[N-1:0];
  end

  // Clearing sources: write-one-to-clear on status, read-to-clear on vector.
  assign w1c_vec = (wr && hit_status) ? wdata[N-1:0] : '0;
  assign vec_clr = (rd && hit_vector) ? grant : '0;

  always_comb begin
    rdata = '0;
    if (hit_enable) begin
      rdata[N-1:0] = enable;
    end else if (hit_status) begin
      rdata[N-1:0]          = flags;
      rdata[BIT_SHIFT_FULL] = shift_full;
      rdata[BIT_BUS_BUSY]   = bus_busy;
    end else if (hit_vector) begin
      rdata[CW-1:0] = code;
    end
  end
endmodule

// File: rtl/evt_vector_ctrl.sv
module evt_vector_ctrl #(
  parameter int DATA_W  = evc_pkg::EVC_DATA_W,
  parameter int ADDR_W  = evc_pkg::EVC_ADDR_W,
  parameter int NUM_EVT = evc_pkg::EVC_NUM_EVT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_arb_lost,
  input  logic              evt_nack,
  input  logic              evt_acc_rdy,
  input  logic              evt_rx_rdy,
  input  logic              evt_tx_rdy,
  input  logic              evt_stop,
  input  logic              evt_slave_addr,
  input  logic              lvl_shift_full,
  input  logic              lvl_bus_busy,
  output logic              irq
);
  localparam int CODE_W = $clog2(NUM_EVT + 1);

  logic [NUM_EVT-1:0] evt_vec;
  logic [NUM_EVT-1:0] flags;
  logic [NUM_EVT-1:0] enable;
  logic [NUM_EVT-1:0] pending;
  logic [NUM_EVT-1:0] grant;
  logic [NUM_EVT-1:0] w1c_vec;
  logic [NUM_EVT-1:0] vec_clr;
  logic [NUM_EVT-1:0] clr_vec;
  logic [CODE_W-1:0]  vec_code;
  logic               any_pending;

  // Bit order of the event vector sets the priority: bit 0 is the highest.
  assign evt_vec = NUM_EVT'({evt_slave_addr, evt_stop, evt_tx_rdy, evt_rx_rdy,
                             evt_acc_rdy, evt_nack, evt_arb_lost});
  assign clr_vec = w1c_vec | vec_clr;
  assign pending = flags & enable;
  assign irq     = any_pending;

  evc_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (evt_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  evc_prio_enc #(.N(NUM_EVT), .CW(CODE_W)) u_enc (
    .pending (pending),
    .grant   (grant),
    .code    (vec_code),
    .any     (any_pending)
  );

  evc_reg_if #(.DW(DATA_W), .AW(ADDR_W), .N(NUM_EVT), .CW(CODE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (reg_addr),
    .wr         (reg_wr),
    .rd         (reg_rd),
    .wdata      (reg_wdata),
    .flags      (flags),
    .shift_full (lvl_shift_full),
    .bus_busy   (lvl_bus_busy),
    .grant      (grant),
    .code       (vec_code),
    .rdata      (reg_rdata),
    .enable     (enable),
    .w1c_vec    (w1c_vec),
    .vec_clr    (vec_clr)
  );
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int N  = 7,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  evt_vec,
  input logic [N-1:0]  flags,
  input logic [N-1:0]  enable,
  input logic [N-1:0]  clr_vec,
  input logic [N-1:0]  vec_clr,
  input logic [CW-1:0] code,
  input logic          irq
);
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(flags & enable))); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((flags & $past(evt_vec)) == $past(evt_vec))); // R8
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec != '0) && (evt_vec == '0)) |=> ((flags & $past(clr_vec)) == '0)); // R3
  AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec == '0) |=> ((flags & ~$past(flags)) == '0)); // R2
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & enable) == '0) |-> (code == '0)); // R4
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(code) <= N); // R4
  AST_VCLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_clr)); // R6
endmodule

bind evt_vector_ctrl evc_checker #(.N(NUM_EVT), .CW(CODE_W)) u_evc_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_vec (evt_vec),
  .flags   (flags),
  .enable  (enable),
  .clr_vec (clr_vec),
  .vec_clr (vec_clr),
  .code    (vec_code),
  .irq     (irq)
);

// File: tb/evt_vector_ctrl_tb.sv
module evt_vector_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_EN  = 6'h04;
  localparam logic [5:0] A_ST  = 6'h08;
  localparam logic [5:0] A_VEC = 6'h28;

  // {pulses[6:0], enable[6:0], expected code[2:0], expected irq}
  localparam int NTBL = 11;
  localparam logic [17:0] VEC_TBL [NTBL] = '{
    {7'h7F, 7'h7F, 3'd1, 1'b1},
    {7'h7E, 7'h7F, 3'd2, 1'b1},
    {7'h7C, 7'h7F, 3'd3, 1'b1},
    {7'h78, 7'h7F, 3'd4, 1'b1},
    {7'h70, 7'h7F, 3'd5, 1'b1},
    {7'h60, 7'h7F, 3'd6, 1'b1},
    {7'h40, 7'h7F, 3'd7, 1'b1},
    {7'h7F, 7'h00, 3'd0, 1'b0},
    {7'h7F, 7'h60, 3'd6, 1'b1},
    {7'h14, 7'h10, 3'd5, 1'b1},
    {7'h01, 7'h7E, 3'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [6:0]  evts = '0;
  logic        lvl_shift_full = 1'b0;
  logic        lvl_bus_busy = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_vector_ctrl dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_rd         (reg_rd),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .evt_arb_lost   (evts[0]),
    .evt_nack       (evts[1]),
    .evt_acc_rdy    (evts[2]),
    .evt_rx_rdy     (evts[3]),
    .evt_tx_rdy     (evts[4]),
    .evt_stop       (evts[5]),
    .evt_slave_addr (evts[6]),
    .lvl_shift_full (lvl_shift_full),
    .lvl_bus_busy   (lvl_bus_busy),
    .irq            (irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Combinational look at a register without the read strobe.
  task automatic peek(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Strobed read: returns the value before the edge, side effects at the edge.
  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] p);
    @(negedge clk);
    evts = p;
    @(negedge clk);
    evts = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [17:0] ent;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    peek(A_EN, d);  check("R11 enable", d, 16'h0000);
    peek(A_ST, d);  check("R11 status", d, 16'h0000);
    peek(A_VEC, d); check("R11 vector", d, 16'h0000);
    check("R11 irq", {15'h0, irq}, 16'h0000);

    // R1: only bits 0..6 of enable are kept
    wr(A_EN, 16'hFFFF);
    peek(A_EN, d); check("R1 enable readback", d, 16'h007F);

    // Table walk: R2 R4 R5 R7 R10
    for (int i = 0; i < NTBL; i++) begin
      ent = VEC_TBL[i];
      wr(A_ST, 16'h007F);
      wr(A_EN, {9'h0, ent[10:4]});
      pulse(ent[17:11]);
      peek(A_ST, d);  check("R2 R10 status flags", d, {9'h0, ent[17:11]});
      peek(A_VEC, d); check("R4 R5 vector code", d, {13'h0, ent[3:1]});
      check("R7 irq", {15'h0, irq}, {15'h0, ent[0]});
    end

    // R3: writing zeros keeps flags, writing one clears only that flag
    wr(A_EN, 16'h007F);
    wr(A_ST, 16'h007F);
    pulse(7'h7F);
    wr(A_ST, 16'h0000);
    peek(A_ST, d); check("R3 write zero no effect", d, 16'h007F);
    wr(A_ST, 16'h0004);
    peek(A_ST, d); check("R3 write one clears bit 2", d, 16'h007B);

    // R6 R5: drain pending codes by strobed vector reads
    wr(A_ST, 16'h007F);
    pulse(7'h2A);
    rd(A_VEC, d); check("R6 drain first", d, 16'd2);
    rd(A_VEC, d); check("R6 drain second", d, 16'd4);
    rd(A_VEC, d); check("R6 drain third", d, 16'd6);
    rd(A_VEC, d); check("R6 drain empty", d, 16'd0);
    check("R6 irq after drain", {15'h0, irq}, 16'h0000);

    // R8: pulse together with a status write clear
    pulse(7'h04);
    @(negedge clk);
    reg_addr = A_ST; reg_wdata = 16'h0004; reg_wr = 1'b1; evts = 7'h04;
    @(negedge clk);
    reg_wr = 1'b0; evts = '0;
    peek(A_ST, d); check("R8 set beats w1c", d, 16'h0004);

    // R8: pulse together with a vector read clear
    wr(A_ST, 16'h007F);
    pulse(7'h02);
    @(negedge clk);
    reg_addr = A_VEC; reg_rd = 1'b1; evts = 7'h02;
    @(negedge clk);
    reg_rd = 1'b0; evts = '0;
    peek(A_VEC, d); check("R8 set beats vector read", d, 16'd2);

    // R9: level bits follow inputs, never vector, cannot be cleared
    wr(A_ST, 16'h007F);
    @(negedge clk);
    lvl_shift_full = 1'b1; lvl_bus_busy = 1'b1;
    wr(A_ST, 16'h1800);
    peek(A_ST, d);  check("R9 level bits stay", d, 16'h1800);
    peek(A_VEC, d); check("R9 no vector from levels", d, 16'h0000);
    check("R9 no irq from levels", {15'h0, irq}, 16'h0000);
    @(negedge clk);
    lvl_shift_full = 1'b0;
    peek(A_ST, d);  check("R9 shift full follows input", d, 16'h1000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule